// File: doc/BRIEF.md
# Operand Address Generator

This unit resolves the operand of an 8-bit processor instruction once the opcode has already been fetched and decoded into an addressing-mode code. A one-cycle `start` pulse hands over the mode, a dereference-suppress flag and the current X and Y index values. The unit then reads the operand bytes that follow the opcode through a byte-wide synchronous read port. It advances its own program counter for each byte. When the mode calls for it, the unit also reads a 16-bit pointer. It forms the 16-bit effective address and, by default, reads the operand byte stored there.

When the dereference flag is set, the final read is skipped and the computed address is returned in place of the value. A listing tool uses this mode to print operands without touching data memory. The unit also holds the reset values of the program counter, the stack pointer and the status byte. An illegal mode code produces a one-cycle error pulse instead of completion.

The memory port is synchronous: a byte requested with `memRd` high in one cycle is presented on `memData` in the following cycle.

Top module: `opnd_addr_gen`

## Requirements
- R1: After reset, `pcOut` is 0x0000, `spOut` is 0xFD, `statusOut` is 0x20 (only the always-one bit 5 set), `effAddr` and `opValue` are 0, and `done`, `badMode` and `memRd` are low.
- R2: Mode codes 0 (accumulator) and 1 (implied) read no bytes, leave the PC unchanged, and finish with `effAddr` = 0 and `opValue` = 0.
- R3: Mode code 2 (immediate) reads one byte at the PC and advances the PC by 1. It finishes with `effAddr` and `opValue` both equal to that byte, zero-extended, and makes no further read whatever the dereference flag.
- R4: Mode codes 3 (zero page), 9 (zero page + X) and 10 (zero page + Y) read one byte and advance the PC by 1. The address is that byte, plus X or Y where the mode says so, with the sum wrapped to 8 bits so the high address byte is 0.
- R5: Mode codes 4 (absolute), 7 (absolute + X) and 8 (absolute + Y) read two bytes, first byte low, and advance the PC by 2. The address is the 16-bit value, plus X or Y with 16-bit wrap. X and Y are taken in the cycle `start` is accepted.
- R6: Mode code 5 (relative) reads one offset byte. The address is the PC value after that byte, plus the offset sign-extended to 16 bits.
- R7: Mode code 6 (indirect) reads a two-byte address A, then reads a pointer from A (low) and A+1 (high, 16-bit wrap). The pointer is the address.
- R8: Mode code 11 (pre-indexed indirect) reads byte Z and reads a pointer from (Z+X) mod 256 (low) and (Z+X+1) mod 256 (high). The pointer is the address.
- R9: Mode code 12 (post-indexed indirect) reads byte Z and reads a pointer from Z (low) and (Z+1) mod 256 (high). The address is the pointer plus Y with 16-bit wrap.
- R10: With the dereference flag low, modes 3 to 12 return in `opValue` the memory byte at `effAddr`, zero-extended.
- R11: With the dereference flag high, modes 3 to 12 return `effAddr` as `opValue` and omit the final memory read.
- R12: Codes 13 to 15 raise `badMode` for exactly one cycle, one cycle after `start`. They make no read, leave the PC unchanged and do not raise `done`.
- R13: `done` is high for exactly one cycle. It rises L cycles after the `start` edge, where L = 2 + (N>0 ? N+1 : 0) + (pointer modes ? 3 : 0) + (final read ? 2 : 0) and N is the number of operand bytes.
- R14: The number of cycles with `memRd` high per operation is N, plus 2 for pointer modes, plus 1 for a final read. Every byte is captured in the cycle after its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| mode | input | 4 | Addressing-mode code |
| noDeref | input | 1 | Skip the final operand read and return the address |
| regX | input | 8 | X index value |
| regY | input | 8 | Y index value |
| memData | input | 8 | Read data, valid the cycle after a request |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read request |
| effAddr | output | 16 | Effective address |
| opValue | output | 16 | Operand value (or address when not dereferenced) |
| pcOut | output | 16 | Program counter |
| spOut | output | 8 | Stack pointer |
| statusOut | output | 8 | Status byte |
| done | output | 1 | One-cycle completion pulse |
| badMode | output | 1 | One-cycle illegal-mode pulse |

## Verification
In two cases a returned byte is captured in the same cycle that the next request goes out. The first is the low operand byte followed by the high-byte fetch. The second is the low pointer byte followed by the pointer high-byte fetch. Both overlaps are provoked by sweeping every mode against both dereference settings, four operand pairs chosen near wrap points and four X/Y pairs. An overlap is judged correct when the effective address, operand value, PC advance, read count and latency all match values the bench computes arithmetically from its own memory image. The X and Y inputs are changed right after `start` is accepted, so a unit that reads them late produces a wrong address.

// File: rtl/oag_pkg.sv
`timescale 1ns/1ps
package oag_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int MW = 4;
  localparam int PW = AW - DW;

  typedef enum logic [MW-1:0] {
    M_ACC = 4'd0,  M_IMP = 4'd1,  M_IMM = 4'd2,  M_ZP  = 4'd3,
    M_ABS = 4'd4,  M_REL = 4'd5,  M_IND = 4'd6,  M_ABX = 4'd7,
    M_ABY = 4'd8,  M_ZPX = 4'd9,  M_ZPY = 4'd10, M_IZX = 4'd11,
    M_IZY = 4'd12
  } amode_e;

  localparam logic [MW-1:0] LAST_MODE = 4'd12;

  typedef enum logic [1:0] {SEL_PC, SEL_PLO, SEL_PHI, SEL_EFF} rdSel_e;

  typedef struct packed {
    logic   latch;
    logic   rdEn;
    rdSel_e sel;
    logic   pcInc;
    logic   capLo;
    logic   capHi;
    logic   capPtrLo;
    logic   capPtrHi;
    logic   formEff;
    logic   capVal;
  } dpCtl_t;

  function automatic logic modeKnown(input logic [MW-1:0] m);
    return m <= LAST_MODE;
  endfunction

  function automatic logic [1:0] opBytes(input logic [MW-1:0] m);
    logic [1:0] n;
    case (m)
      M_ACC, M_IMP:               n = 2'd0;
      M_ABS, M_IND, M_ABX, M_ABY: n = 2'd2;
      default:                    n = 2'd1;
    endcase
    return n;
  endfunction

  function automatic logic usesPtr(input logic [MW-1:0] m);
    return (m == M_IND) || (m == M_IZX) || (m == M_IZY);
  endfunction

  function automatic logic isMemMode(input logic [MW-1:0] m);
    return (m >= M_ZP) && (m <= LAST_MODE);
  endfunction
endpackage

// File: rtl/oag_ctrl.sv
`timescale 1ns/1ps
module oag_ctrl
  import oag_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] modeIn,
  input  logic [MW-1:0] modeR,
  input  logic          derefNeed,
  output dpCtl_t        ctl,
  output logic          done,
  output logic          badMode
);
  typedef enum logic [3:0] {
    S_IDLE, S_OPA, S_OPB, S_OPC, S_PTA, S_PTB, S_PTC,
    S_CALC, S_DRA, S_DRB, S_FIN, S_ERR
  } state_e;

  state_e st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    ctl     = '0;
    nxt     = st;
    done    = 1'b0;
    badMode = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (start) begin
          ctl.latch = 1'b1;
          if (!modeKnown(modeIn))       nxt = S_ERR;
          else if (opBytes(modeIn) == 0) nxt = S_CALC;
          else                          nxt = S_OPA;
        end
      end
      S_OPA: begin
        ctl.rdEn  = 1'b1;
        ctl.sel   = SEL_PC;
        ctl.pcInc = 1'b1;
        nxt       = S_OPB;
      end
      S_OPB: begin
        ctl.capLo = 1'b1;
        if (opBytes(modeR) == 2'd2) begin
          ctl.rdEn  = 1'b1;
          ctl.sel   = SEL_PC;
          ctl.pcInc = 1'b1;
          nxt       = S_OPC;
        end else begin
          nxt = usesPtr(modeR) ? S_PTA : S_CALC;
        end
      end
      S_OPC: begin
        ctl.capHi = 1'b1;
        nxt       = usesPtr(modeR) ? S_PTA : S_CALC;
      end
      S_PTA: begin
        ctl.rdEn = 1'b1;
        ctl.sel  = SEL_PLO;
        nxt      = S_PTB;
      end
      S_PTB: begin
        ctl.capPtrLo = 1'b1;
        ctl.rdEn     = 1'b1;
        ctl.sel      = SEL_PHI;
        nxt          = S_PTC;
      end
      S_PTC: begin
        ctl.capPtrHi = 1'b1;
        nxt          = S_CALC;
      end
      S_CALC: begin
        ctl.formEff = 1'b1;
        nxt         = derefNeed ? S_DRA : S_FIN;
      end
      S_DRA: begin
        ctl.rdEn = 1'b1;
        ctl.sel  = SEL_EFF;
        nxt      = S_DRB;
      end
      S_DRB: begin
        ctl.capVal = 1'b1;
        nxt        = S_FIN;
      end
      S_FIN: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      S_ERR: begin
        badMode = 1'b1;
        nxt     = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  // R13: completion is a single-cycle pulse
  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R12: illegal-mode flag is a single-cycle pulse
  p_bad_pulse_r12: assert property (@(posedge clk) disable iff (!rstN)
    badMode |=> !badMode);
endmodule

// File: rtl/oag_dp.sv
`timescale 1ns/1ps
module oag_dp
  import oag_pkg::*;
#(
  parameter logic [DW-1:0] SP_RESET   = 8'hFD,
  parameter logic [DW-1:0] STAT_RESET = 8'h20
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic [MW-1:0] modeIn,
  input  logic          noDerefIn,
  input  logic [DW-1:0] xIn,
  input  logic [DW-1:0] yIn,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic [MW-1:0] modeR,
  output logic          derefNeed,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] opValue,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] statusOut
);
  logic          ndR;
  logic [DW-1:0] xR, yR, loR, hiR, ptrLoR, ptrHiR, spR, statR;
  logic [AW-1:0] pcR, effR, valR, effNext, ptrVal, absVal;
  logic [AW-1:0] ptrLoAddr, ptrHiAddr;
  logic [DW-1:0] zpBase;

  assign absVal = {hiR, loR};
  assign ptrVal = {ptrHiR, ptrLoR};
  assign zpBase = (modeR == M_IZX) ? DW'(loR + xR) : loR;

  always_comb begin
    if (modeR == M_IND) begin
      ptrLoAddr = absVal;
      ptrHiAddr = absVal + 1'b1;
    end else begin
      ptrLoAddr = {{PW{1'b0}}, zpBase};
      ptrHiAddr = {{PW{1'b0}}, DW'(zpBase + 1'b1)};
    end
  end

  always_comb begin
    case (modeR)
      M_IMM, M_ZP: effNext = {{PW{1'b0}}, loR};
      M_ABS:       effNext = absVal;
      M_REL:       effNext = pcR + {{PW{loR[DW-1]}}, loR};
      M_IND:       effNext = ptrVal;
      M_ABX:       effNext = absVal + {{PW{1'b0}}, xR};
      M_ABY:       effNext = absVal + {{PW{1'b0}}, yR};
      M_ZPX:       effNext = {{PW{1'b0}}, DW'(loR + xR)};
      M_ZPY:       effNext = {{PW{1'b0}}, DW'(loR + yR)};
      M_IZX:       effNext = ptrVal;
      M_IZY:       effNext = ptrVal + {{PW{1'b0}}, yR};
      default:     effNext = '0;
    endcase
  end

  always_comb begin
    case (ctl.sel)
      SEL_PC:  memAddr = pcR;
      SEL_PLO: memAddr = ptrLoAddr;
      SEL_PHI: memAddr = ptrHiAddr;
      default: memAddr = effR;
    endcase
  end

  assign memRd     = ctl.rdEn;
  assign derefNeed = !ndR && isMemMode(modeR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeR  <= '0;
      ndR    <= 1'b0;
      xR     <= '0;
      yR     <= '0;
      loR    <= '0;
      hiR    <= '0;
      ptrLoR <= '0;
      ptrHiR <= '0;
      effR   <= '0;
      valR   <= '0;
      pcR    <= '0;
      spR    <= SP_RESET;
      statR  <= STAT_RESET;
    end else begin
      if (ctl.latch) begin
        modeR  <= modeIn;
        ndR    <= noDerefIn;
        xR     <= xIn;
        yR     <= yIn;
        loR    <= '0;
        hiR    <= '0;
        ptrLoR <= '0;
        ptrHiR <= '0;
      end
      if (ctl.pcInc)    pcR    <= pcR + 1'b1;
      if (ctl.capLo)    loR    <= memData;
      if (ctl.capHi)    hiR    <= memData;
      if (ctl.capPtrLo) ptrLoR <= memData;
      if (ctl.capPtrHi) ptrHiR <= memData;
      if (ctl.formEff) begin
        effR <= effNext;
        valR <= (modeR == M_IMM) ? {{PW{1'b0}}, loR} : effNext;
      end
      if (ctl.capVal)   valR   <= {{PW{1'b0}}, memData};
    end
  end

  assign effAddr   = effR;
  assign opValue   = valR;
  assign pcOut     = pcR;
  assign spOut     = spR;
  assign statusOut = statR;

  // R3: the program counter only ever steps forward by one
  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pcR != $past(pcR)) |-> (pcR == $past(pcR) + 1'b1));

  // R11: no final operand read while dereference is suppressed
  p_noderef_no_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && ctl.sel == SEL_EFF) |-> !ndR);

  // R14: every byte capture follows a read request one cycle earlier
  p_cap_after_rd_r14: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capLo || ctl.capHi || ctl.capPtrLo || ctl.capPtrHi || ctl.capVal)
      |-> $past(ctl.rdEn));

  // R7: the pointer high-byte read directly follows the pointer low-byte read
  p_ptr_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rdEn && ctl.sel == SEL_PHI) |-> $past(ctl.rdEn && ctl.sel == SEL_PLO));
endmodule

// File: rtl/opnd_addr_gen.sv
`timescale 1ns/1ps
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter logic [DW-1:0] SP_RESET   = 8'hFD,
  parameter logic [DW-1:0] STAT_RESET = 8'h20
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [MW-1:0] mode,
  input  logic          noDeref,
  input  logic [DW-1:0] regX,
  input  logic [DW-1:0] regY,
  input  logic [DW-1:0] memData,
  output logic [AW-1:0] memAddr,
  output logic          memRd,
  output logic [AW-1:0] effAddr,
  output logic [AW-1:0] opValue,
  output logic [AW-1:0] pcOut,
  output logic [DW-1:0] spOut,
  output logic [DW-1:0] statusOut,
  output logic          done,
  output logic          badMode
);
  dpCtl_t        ctl;
  logic [MW-1:0] modeR;
  logic          derefNeed;

  oag_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .modeIn    (mode),
    .modeR     (modeR),
    .derefNeed (derefNeed),
    .ctl       (ctl),
    .done      (done),
    .badMode   (badMode)
  );

  oag_dp #(
    .SP_RESET   (SP_RESET),
    .STAT_RESET (STAT_RESET)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .modeIn    (mode),
    .noDerefIn (noDeref),
    .xIn       (regX),
    .yIn       (regY),
    .memData   (memData),
    .memAddr   (memAddr),
    .memRd     (memRd),
    .modeR     (modeR),
    .derefNeed (derefNeed),
    .effAddr   (effAddr),
    .opValue   (opValue),
    .pcOut     (pcOut),
    .spOut     (spOut),
    .statusOut (statusOut)
  );
endmodule

// File: tb/opnd_addr_gen_bench.sv
`timescale 1ns/1ps
module opnd_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic        noDeref = 1'b0;
  logic [7:0]  regX = '0, regY = '0;
  logic [7:0]  memData = '0;
  logic [15:0] memAddr, effAddr, opValue, pcOut;
  logic        memRd, done, badMode;
  logic [7:0]  spOut, statusOut;

  logic [7:0]  mem [0:65535];
  int          nChk = 0, nFail = 0, cycles = 0;
  logic [15:0] expPc = '0;

  opnd_addr_gen u_opnd_addr_gen (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .noDeref(noDeref),
    .regX(regX), .regY(regY), .memData(memData), .memAddr(memAddr),
    .memRd(memRd), .effAddr(effAddr), .opValue(opValue), .pcOut(pcOut),
    .spOut(spOut), .statusOut(statusOut), .done(done), .badMode(badMode)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) if (memRd) memData <= mem[memAddr];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nFail++;
      $display("FAIL R13 watchdog: actual %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic runTxn(input int m, input bit nd, input logic [7:0] x,
                        input logic [7:0] y, input logic [7:0] b0,
                        input logic [7:0] b1, input logic [7:0] p0,
                        input logic [7:0] p1);
    logic [15:0] pc0, eff, val, pa;
    logic [7:0]  z;
    int          nb, ptr, der, lat, cyc, rds;
    string       rq;
    bit          bad;
    pc0 = expPc;
    mem[pc0] = b0;
    mem[16'(pc0 + 1)] = b1;
    nb = 1; ptr = 0; eff = '0; bad = 0;
    case (m)
      0, 1: begin nb = 0; rq = "R2"; end
      2:  begin eff = {8'h00, b0}; rq = "R3"; end
      3:  begin eff = {8'h00, b0}; rq = "R4"; end
      4:  begin nb = 2; eff = {b1, b0}; rq = "R5"; end
      5:  begin eff = 16'(pc0 + 1 + {{8{b0[7]}}, b0}); rq = "R6"; end
      6:  begin nb = 2; ptr = 1; pa = {b1, b0}; mem[pa] = p0;
                mem[16'(pa + 1)] = p1; eff = {p1, p0}; rq = "R7"; end
      7:  begin nb = 2; eff = 16'({b1, b0} + x); rq = "R5"; end
      8:  begin nb = 2; eff = 16'({b1, b0} + y); rq = "R5"; end
      9:  begin eff = {8'h00, 8'(b0 + x)}; rq = "R4"; end
      10: begin eff = {8'h00, 8'(b0 + y)}; rq = "R4"; end
      11: begin ptr = 1; z = 8'(b0 + x); mem[{8'h00, z}] = p0;
                mem[{8'h00, 8'(z + 1)}] = p1; eff = {p1, p0}; rq = "R8"; end
      12: begin ptr = 1; mem[{8'h00, b0}] = p0;
                mem[{8'h00, 8'(b0 + 1)}] = p1; eff = 16'({p1, p0} + y); rq = "R9"; end
      default: begin nb = 0; bad = 1; rq = "R12"; end
    endcase
    der = (m >= 3 && m <= 12 && !nd) ? 1 : 0;
    if (m <= 1) val = '0;
    else if (m == 2) val = {8'h00, b0};
    else if (der == 1) val = {8'h00, mem[eff]};
    else val = eff;
    lat = 2 + ((nb > 0) ? nb + 1 : 0) + ptr * 3 + der * 2;

    @(negedge clk);
    mode = 4'(m); noDeref = nd; regX = x; regY = y; start = 1'b1;
    cyc = 0; rds = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      start = 1'b0; regX = ~x; regY = ~y;
      cyc++;
      if (memRd) rds++;
      if (done || badMode || cyc > 40) break;
    end

    if (bad) begin
      chk("R12", "badMode", {31'b0, badMode}, 32'd1);
      chk("R12", "badMode cycle", cyc, 1);
      chk("R12", "no done", {31'b0, done}, 32'd0);
      chk("R12", "reads", rds, 0);
      @(negedge clk);
      chk("R12", "badMode pulse", {31'b0, badMode}, 32'd0);
      chk("R12", "no done later", {31'b0, done}, 32'd0);
      chk("R12", "pc", pcOut, expPc);
    end else begin
      expPc = 16'(pc0 + nb);
      chk(rq, "effAddr", effAddr, eff);
      if (der == 1)                chk("R10", "opValue", opValue, val);
      else if (m >= 3)             chk("R11", "opValue", opValue, val);
      else                         chk(rq, "opValue", opValue, val);
      chk((nb == 2) ? "R5" : (nb == 1) ? "R3" : "R2", "pc", pcOut, expPc);
      chk("R13", "latency", cyc, lat);
      chk((nd && m >= 3) ? "R11" : "R14", "reads", rds, nb + ptr * 2 + der);
      @(negedge clk);
      chk("R13", "done pulse", {31'b0, done}, 32'd0);
    end
  endtask

  initial begin
    logic [7:0] b0s [4];
    logic [7:0] b1s [4];
    logic [7:0] xs  [4];
    logic [7:0] ys  [4];
    b0s = '{8'hFF, 8'h00, 8'h80, 8'h37};
    b1s = '{8'hFF, 8'h80, 8'hC3, 8'h9A};
    xs  = '{8'h00, 8'h01, 8'hFF, 8'h80};
    ys  = '{8'hFF, 8'h00, 8'h7F, 8'h01};
    for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 37 + (i >> 8) * 11 + 3);

    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    chk("R1", "pc", pcOut, 16'h0000);
    chk("R1", "sp", spOut, 8'hFD);
    chk("R1", "status", statusOut, 8'h20);
    chk("R1", "effAddr", effAddr, 16'h0000);
    chk("R1", "opValue", opValue, 16'h0000);
    chk("R1", "done/bad/rd", {29'b0, done, badMode, memRd}, 32'd0);

    for (int i = 0; i < 300; i++)
      runTxn(2, i[0], 8'(i), 8'(~i), 8'(i ^ 8'h5A), 8'(i * 3), 8'h00, 8'h00);

    for (int m = 0; m < 16; m++)
      for (int nd = 0; nd < 2; nd++)
        for (int k = 0; k < 4; k++)
          for (int j = 0; j < 4; j++)
            runTxn(m, nd[0], xs[j], ys[j], b0s[k], b1s[k],
                   8'(k * 53 + j * 17 + m), 8'(k * 29 + j * 71 + 8'h11));

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule